// File: doc/BRIEF.md
# Call Gate Stack Switch Engine

This block performs the stack traffic of a far call made through a call gate. When the call raises privilege it moves onto a new stack. It first saves the caller's stack selector and stack pointer on that new stack. It then copies a given number of parameters across from the caller's stack. Finally it pushes the caller's code selector and the return pointer. When privilege stays the same, the block skips the switch and the copy, and pushes only the code selector and the return pointer on the current stack. Gate checks and descriptor loading happen outside the block.

Each stack has a base address and a pointer mask. A stack whose descriptor has its big flag clear wraps its pointer within 64 KiB, and the upper pointer bits are left untouched. The block reads parameters from the caller's stack with that stack's own mask. It writes to the target stack with the target stack's mask. Parameters are taken from the highest index down to index 0, so their order is the same on both stacks. The gate size decides whether every item is 2 bytes or 4 bytes.

The engine is a state machine with these states: IDLE, PUSH_SS, PUSH_SP, RD_PARM, WR_PARM, PUSH_CS, PUSH_IP, FIN. Its transitions are:
- IDLE to PUSH_SS, on an accepted start with a privilege change.
- IDLE to PUSH_CS, on an accepted start without a privilege change.
- PUSH_SS to PUSH_SP.
- PUSH_SP to RD_PARM, when the count is not zero.
- PUSH_SP to PUSH_CS, when the count is zero.
- RD_PARM to WR_PARM.
- WR_PARM to RD_PARM, while parameters remain.
- WR_PARM to PUSH_CS, after the last parameter.
- PUSH_CS to PUSH_IP.
- PUSH_IP to FIN.
- FIN to IDLE.

Memory is a single port with combinational read data. At most one access is made per cycle.

Top module: `gate_stack_switch`

## Requirements
- R1: After reset, busy, done, mem_rd and mem_wr are all 0.
- R2: With priv_chg=1, the first two writes go to the new stack. The first carries old_ss_sel and the second carries old_sp. Each write pre-decrements the pointer by the item size and goes to new_base + (pointer AND new mask).
- R3: Parameter i is read at old_base + ((old_sp + i*size) AND old mask). Indices run from param_cnt-1 down to 0, and each value read is written as the next push on the new stack.
- R4: With gate32=1 every item is 4 bytes and mem_wide=1. With gate32=0 every item is 2 bytes, mem_wide=0, and mem_wdata carries the low 16 bits of the value, zero-extended.
- R5: The last two writes of every call are cs_sel and then ret_ip.
- R6: With priv_chg=0, only cs_sel and ret_ip are written. They go to the old stack, and no read is issued.
- R7: A stack with its big flag at 0 uses mask 0x0000FFFF and a stack with its big flag at 1 uses mask 0xFFFFFFFF. The 16-bit pointer wraps, and sp_out keeps the pointer bits outside the mask from the starting pointer.
- R8: Parameter reads use the old stack's mask, even when it differs from the new stack's mask.
- R9: A param_cnt of 0 copies nothing. The maximum count of 31 copies all 31 parameters.
- R10: Each parameter takes one read cycle followed directly by one write cycle. mem_rd and mem_wr are never 1 together.
- R11: done is a one-cycle pulse in the cycle after the last push. sp_out in that cycle holds the final target stack pointer.
- R12: A start pulse while busy=1 is ignored. The running call's traffic and result are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a call; accepted only when idle |
| priv_chg | input | 1 | 1 = switch to the new stack and copy parameters |
| gate32 | input | 1 | 1 = 4-byte items, 0 = 2-byte items |
| param_cnt | input | CW | Number of parameters to copy |
| old_ss_sel | input | 16 | Caller stack selector |
| old_sp | input | AW | Caller stack pointer |
| old_base | input | AW | Caller stack base address |
| old_big | input | 1 | Caller stack big flag |
| new_sp | input | AW | Target stack pointer on a privilege change |
| new_base | input | AW | Target stack base address |
| new_big | input | 1 | Target stack big flag |
| cs_sel | input | 16 | Caller code selector |
| ret_ip | input | AW | Return instruction pointer |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| mem_wide | output | 1 | 1 = 4-byte access, 0 = 2-byte access |
| mem_addr | output | AW | Access address |
| mem_wdata | output | AW | Write data |
| mem_rdata | input | AW | Read data, valid in the same cycle as mem_rd |
| busy | output | 1 | A call is in progress |
| done | output | 1 | One-cycle completion pulse |
| sp_out | output | AW | Updated target stack pointer |

## Verification
A corrupted pointer register appears at the very next push as a wrong write address, one cycle later. It also appears as a wrong sp_out at done. A wrong remaining-count or index register shows at the next read address and changes the number of writes before done. A wrong state shows within one cycle, as a missing, extra or reordered access, or as a done pulse that comes at the wrong time.

// File: rtl/gss_pkg.sv
package gss_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PUSH_SS,
        ST_PUSH_SP,
        ST_RD_PARM,
        ST_WR_PARM,
        ST_PUSH_CS,
        ST_PUSH_IP,
        ST_FIN
    } gss_state_e;
endpackage

// File: rtl/gss_ctrl.sv
module gss_ctrl
    import gss_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       priv_chg,
    input  logic       more,
    input  logic       last,
    output gss_state_e state,
    output logic       accept,
    output logic       push,
    output logic       rd,
    output logic       done,
    output logic       busy
);
    gss_state_e st_q, st_nxt;

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_nxt;
    end

    always_comb begin
        st_nxt = st_q;
        unique case (st_q)
            ST_IDLE:    if (start) st_nxt = priv_chg ? ST_PUSH_SS : ST_PUSH_CS;
            ST_PUSH_SS: st_nxt = ST_PUSH_SP;
            ST_PUSH_SP: st_nxt = more ? ST_RD_PARM : ST_PUSH_CS;
            ST_RD_PARM: st_nxt = ST_WR_PARM;
            ST_WR_PARM: st_nxt = last ? ST_PUSH_CS : ST_RD_PARM;
            ST_PUSH_CS: st_nxt = ST_PUSH_IP;
            ST_PUSH_IP: st_nxt = ST_FIN;
            ST_FIN:     st_nxt = ST_IDLE;
            default:    st_nxt = ST_IDLE;
        endcase
    end

    always_comb begin
        push   = 1'b0;
        rd     = 1'b0;
        done   = 1'b0;
        busy   = 1'b1;
        accept = 1'b0;
        unique case (st_q)
            ST_IDLE: begin
                busy   = 1'b0;
                accept = start;
            end
            ST_PUSH_SS, ST_PUSH_SP, ST_WR_PARM, ST_PUSH_CS, ST_PUSH_IP: push = 1'b1;
            ST_RD_PARM: rd   = 1'b1;
            ST_FIN:     done = 1'b1;
            default:    busy = 1'b0;
        endcase
    end

    assign state = st_q;

    // R10
    rd_then_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd |=> (push && state == ST_WR_PARM));

    // R11
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));

    // R6
    same_priv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !priv_chg) |=> (state == ST_PUSH_CS));

    // R12
    ignore_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);
endmodule

// File: rtl/gss_ptr.sv
module gss_ptr #(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          priv_chg,
    input  logic          old_big,
    input  logic          new_big,
    input  logic [AW-1:0] old_sp,
    input  logic [AW-1:0] old_base,
    input  logic [AW-1:0] new_sp,
    input  logic [AW-1:0] new_base,
    input  logic          wide,
    input  logic          push,
    output logic [AW-1:0] waddr,
    output logic [AW-1:0] sp_out
);
    localparam logic [AW-1:0] MASK_FULL = '1;
    localparam logic [AW-1:0] MASK_LO   = {{(AW-16){1'b0}}, 16'hFFFF};

    logic [AW-1:0] sp_q, base_q, mask_q;
    logic [AW-1:0] step, dec, sp_nxt;

    assign step   = wide ? AW'(4) : AW'(2);
    assign dec    = sp_q - step;
    assign sp_nxt = (sp_q & ~mask_q) | (dec & mask_q);
    assign waddr  = base_q + (dec & mask_q);
    assign sp_out = sp_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sp_q   <= '0;
            base_q <= '0;
            mask_q <= MASK_FULL;
        end else if (load) begin
            sp_q   <= priv_chg ? new_sp   : old_sp;
            base_q <= priv_chg ? new_base : old_base;
            mask_q <= (priv_chg ? new_big : old_big) ? MASK_FULL : MASK_LO;
        end else if (push) begin
            sp_q <= sp_nxt;
        end
    end

    // R7
    upper_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push |=> ((sp_q & ~mask_q) == ($past(sp_q) & ~mask_q)));
endmodule

// File: rtl/gss_param.sv
module gss_param #(
    parameter int AW = 32,
    parameter int CW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] cnt,
    input  logic [AW-1:0] old_sp,
    input  logic [AW-1:0] old_base,
    input  logic          old_big,
    input  logic          wide,
    input  logic          rd,
    input  logic          wr_parm,
    input  logic [AW-1:0] rdata,
    output logic [AW-1:0] raddr,
    output logic [AW-1:0] pdata,
    output logic          more,
    output logic          last
);
    localparam logic [AW-1:0] MASK_FULL = '1;
    localparam logic [AW-1:0] MASK_LO   = {{(AW-16){1'b0}}, 16'hFFFF};

    logic [CW-1:0] rem_q, idx;
    logic [AW-1:0] osp_q, obase_q, omask_q, pdata_q, off;

    assign idx   = rem_q - CW'(1);
    assign off   = {{(AW-CW){1'b0}}, idx} << (wide ? 2 : 1);
    assign raddr = obase_q + ((osp_q + off) & omask_q);
    assign more  = (rem_q != '0);
    assign last  = (rem_q == CW'(1));
    assign pdata = pdata_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q   <= '0;
            osp_q   <= '0;
            obase_q <= '0;
            omask_q <= MASK_FULL;
            pdata_q <= '0;
        end else begin
            if (load) begin
                rem_q   <= cnt;
                osp_q   <= old_sp;
                obase_q <= old_base;
                omask_q <= old_big ? MASK_FULL : MASK_LO;
            end else if (wr_parm) begin
                rem_q <= rem_q - CW'(1);
            end
            if (rd) pdata_q <= rdata;
        end
    end

    // R9
    no_read_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd |-> more);

    // R3
    count_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_parm && !load) |=> (rem_q != $past(rem_q)));
endmodule

// File: rtl/gate_stack_switch.sv
module gate_stack_switch
    import gss_pkg::*;
#(
    parameter int AW = 32,
    parameter int CW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          priv_chg,
    input  logic          gate32,
    input  logic [CW-1:0] param_cnt,
    input  logic [15:0]   old_ss_sel,
    input  logic [AW-1:0] old_sp,
    input  logic [AW-1:0] old_base,
    input  logic          old_big,
    input  logic [AW-1:0] new_sp,
    input  logic [AW-1:0] new_base,
    input  logic          new_big,
    input  logic [15:0]   cs_sel,
    input  logic [AW-1:0] ret_ip,
    output logic          mem_rd,
    output logic          mem_wr,
    output logic          mem_wide,
    output logic [AW-1:0] mem_addr,
    output logic [AW-1:0] mem_wdata,
    input  logic [AW-1:0] mem_rdata,
    output logic          busy,
    output logic          done,
    output logic [AW-1:0] sp_out
);
    localparam logic [AW-1:0] LO16 = {{(AW-16){1'b0}}, 16'hFFFF};

    gss_state_e    state;
    logic          accept, push, rd, more, last;
    logic          wide_q;
    logic [15:0]   ss_q, cs_q;
    logic [AW-1:0] osp_q, ip_q, waddr, raddr, pdata, wval;

    gss_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .priv_chg(priv_chg),
        .more(more), .last(last), .state(state), .accept(accept),
        .push(push), .rd(rd), .done(done), .busy(busy)
    );

    gss_ptr #(.AW(AW)) u_ptr (
        .clk(clk), .rst_n(rst_n), .load(accept), .priv_chg(priv_chg),
        .old_big(old_big), .new_big(new_big), .old_sp(old_sp),
        .old_base(old_base), .new_sp(new_sp), .new_base(new_base),
        .wide(wide_q), .push(push), .waddr(waddr), .sp_out(sp_out)
    );

    gss_param #(.AW(AW), .CW(CW)) u_param (
        .clk(clk), .rst_n(rst_n), .load(accept), .cnt(param_cnt),
        .old_sp(old_sp), .old_base(old_base), .old_big(old_big),
        .wide(wide_q), .rd(rd), .wr_parm(state == ST_WR_PARM),
        .rdata(mem_rdata), .raddr(raddr), .pdata(pdata),
        .more(more), .last(last)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wide_q <= 1'b0;
            ss_q   <= '0;
            cs_q   <= '0;
            osp_q  <= '0;
            ip_q   <= '0;
        end else if (accept) begin
            wide_q <= gate32;
            ss_q   <= old_ss_sel;
            cs_q   <= cs_sel;
            osp_q  <= old_sp;
            ip_q   <= ret_ip;
        end
    end

    always_comb begin
        wval = '0;
        unique case (state)
            ST_PUSH_SS: wval = {{(AW-16){1'b0}}, ss_q};
            ST_PUSH_SP: wval = osp_q;
            ST_WR_PARM: wval = pdata;
            ST_PUSH_CS: wval = {{(AW-16){1'b0}}, cs_q};
            ST_PUSH_IP: wval = ip_q;
            default:    wval = '0;
        endcase
    end

    assign mem_wdata = wide_q ? wval : (wval & LO16);
    assign mem_wr    = push;
    assign mem_rd    = rd;
    assign mem_wide  = wide_q;
    assign mem_addr  = rd ? raddr : waddr;

    // R4
    narrow_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr && !mem_wide) |-> (mem_wdata[AW-1:16] == '0));

    // R10
    one_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));
endmodule

// File: tb/tb_gate_stack_switch.sv
`timescale 1ns/1ps
module tb_gate_stack_switch;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0, priv_chg = 1'b0, gate32 = 1'b0;
    logic [4:0]  param_cnt = '0;
    logic [15:0] old_ss_sel = '0, cs_sel = '0;
    logic [31:0] old_sp = '0, old_base = '0, new_sp = '0, new_base = '0, ret_ip = '0;
    logic        old_big = 1'b0, new_big = 1'b0;
    logic        mem_rd, mem_wr, mem_wide, busy, done;
    logic [31:0] mem_addr, mem_wdata, mem_rdata, sp_out;

    int checks = 0, bad = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    function automatic logic [31:0] fval(input logic [31:0] a);
        return (a * 32'h9E3779B1) ^ 32'h5A5AC3C3;
    endfunction
    assign mem_rdata = fval(mem_addr);

    gate_stack_switch dut (
        .clk(clk), .rst_n(rst_n), .start(start), .priv_chg(priv_chg),
        .gate32(gate32), .param_cnt(param_cnt), .old_ss_sel(old_ss_sel),
        .old_sp(old_sp), .old_base(old_base), .old_big(old_big),
        .new_sp(new_sp), .new_base(new_base), .new_big(new_big),
        .cs_sel(cs_sel), .ret_ip(ret_ip), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .mem_wide(mem_wide), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .busy(busy), .done(done), .sp_out(sp_out)
    );

    logic [31:0] wa[$], wd[$], ra[$], ea[$], ed[$], er[$];
    logic        ww[$];
    int          ops[$];
    int          both_cnt, done_cnt;
    logic [31:0] sp_done;
    logic [31:0] e_sp, e_base, e_mask;
    bit          e_g32;

    always @(negedge clk) begin
        if (rst_n) begin
            if (mem_wr) begin
                wa.push_back(mem_addr); wd.push_back(mem_wdata);
                ww.push_back(mem_wide); ops.push_back(2);
            end
            if (mem_rd) begin
                ra.push_back(mem_addr); ops.push_back(1);
            end
            if (mem_wr && mem_rd) both_cnt++;
            if (done) begin done_cnt++; sp_done = sp_out; end
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic epush(input logic [31:0] v);
        e_sp = e_sp - (e_g32 ? 32'd4 : 32'd2);
        ea.push_back(e_base + (e_sp & e_mask));
        ed.push_back(e_g32 ? v : (v & 32'hFFFF));
    endtask

    task automatic run_case(input string tag, input bit pc, input bit g32, input int cnt,
                            input logic [31:0] osp, input logic [31:0] obase, input bit obig,
                            input logic [31:0] nsp, input logic [31:0] nbase, input bit nbig,
                            input bit poke);
        logic [31:0] om, init, exp_sp, a;
        bit ok;
        wa.delete(); wd.delete(); ww.delete(); ra.delete(); ops.delete();
        ea.delete(); ed.delete(); er.delete();
        both_cnt = 0; done_cnt = 0; sp_done = '0;
        // expected traffic
        e_g32 = g32;
        om = obig ? 32'hFFFFFFFF : 32'h0000FFFF;
        if (pc) begin
            e_sp = nsp; e_base = nbase; e_mask = nbig ? 32'hFFFFFFFF : 32'h0000FFFF;
        end else begin
            e_sp = osp; e_base = obase; e_mask = om;
        end
        init = e_sp;
        if (pc) begin
            epush({16'h0, 16'h0ABC});
            epush(osp);
            for (int i = cnt - 1; i >= 0; i--) begin
                a = obase + ((osp + i * (g32 ? 4 : 2)) & om);
                er.push_back(a);
                epush(fval(a));
            end
        end
        epush({16'h0, 16'h1D2E});
        epush(32'hC0DE_4321);
        exp_sp = (init & ~e_mask) | (e_sp & e_mask);
        // drive
        @(posedge clk); #1;
        priv_chg = pc; gate32 = g32; param_cnt = 5'(cnt);
        old_ss_sel = 16'h0ABC; cs_sel = 16'h1D2E; ret_ip = 32'hC0DE_4321;
        old_sp = osp; old_base = obase; old_big = obig;
        new_sp = nsp; new_base = nbase; new_big = nbig;
        start = 1'b1;
        @(posedge clk); #1;
        start = 1'b0;
        if (poke) begin
            // R12: second start while busy with different inputs
            @(posedge clk); #1;
            start = 1'b1; priv_chg = ~pc; cs_sel = 16'h7777; ret_ip = 32'h0;
            old_sp = 32'h1234; new_sp = 32'h5678;
            @(posedge clk); #1;
            start = 1'b0;
        end
        for (int c = 0; c < 200 && done_cnt == 0; c++) @(negedge clk);
        repeat (3) @(negedge clk);
        chk(busy == 1'b0, {tag, " R11 idle after done"}, 32'(busy), 32'd0);
        chk(done_cnt == 1, {tag, " R11 one done pulse"}, 32'(done_cnt), 32'd1);
        chk(sp_done == exp_sp, {tag, " R7 R11 sp_out"}, sp_done, exp_sp);
        chk(wa.size() == ea.size(), {tag, " write count"}, 32'(wa.size()), 32'(ea.size()));
        chk(ra.size() == er.size(), {tag, " R6 R9 read count"}, 32'(ra.size()), 32'(er.size()));
        for (int i = 0; i < ea.size() && i < wa.size(); i++) begin
            chk(wa[i] == ea[i], $sformatf("%s write %0d addr", tag, i), wa[i], ea[i]);
            chk(wd[i] == ed[i], $sformatf("%s write %0d data", tag, i), wd[i], ed[i]);
            chk(ww[i] == g32, $sformatf("%s R4 write %0d size", tag, i), 32'(ww[i]), 32'(g32));
        end
        for (int i = 0; i < er.size() && i < ra.size(); i++)
            chk(ra[i] == er[i], $sformatf("%s R3 R8 read %0d addr", tag, i), ra[i], er[i]);
        ok = (both_cnt == 0);
        for (int i = 0; i < ops.size(); i++)
            if (ops[i] == 1 && (i + 1 >= ops.size() || ops[i+1] != 2)) ok = 0;
        chk(ok, {tag, " R10 read-write pairing"}, 32'(both_cnt), 32'd0);
        if (ea.size() >= 2 && wd.size() == ea.size()) begin
            chk(wd[wd.size()-2] == 32'h1D2E, {tag, " R5 cs before ip"}, wd[wd.size()-2], 32'h1D2E);
        end
    endtask

    initial begin
        repeat (4) @(posedge clk);
        #1;
        // R1 reset state
        chk(busy == 0 && done == 0 && mem_wr == 0 && mem_rd == 0, "R1 reset outputs",
            {28'h0, busy, done, mem_wr, mem_rd}, 32'h0);
        rst_n = 1'b1;
        // R2 R3 R5: 32-bit gate, big stacks, three params
        run_case("big3 R2 R3 R5", 1, 1, 3, 32'h0001_0040, 32'h2000_0000, 1,
                 32'h0000_8000, 32'h4000_0000, 1, 0);
        // R4 R7: 16-bit gate, new stack wraps at 64 KiB, upper bits kept
        run_case("wrap16 R4 R7", 1, 0, 2, 32'h0000_0100, 32'h0003_0000, 0,
                 32'hABCD_0002, 32'h0005_0000, 0, 0);
        // R8: old stack 16-bit, reads wrap while new stack is big
        run_case("oldwrap R8", 1, 1, 3, 32'h7777_FFFA, 32'h0010_0000, 0,
                 32'h0000_0400, 32'h0020_0000, 1, 0);
        // R9: zero parameters
        run_case("zero R9", 1, 0, 0, 32'h0000_0200, 32'h0000_1000, 0,
                 32'h0000_0300, 32'h0000_9000, 0, 0);
        // R6: same privilege, only two pushes on the current stack
        run_case("same R6", 0, 1, 4, 32'h0000_0800, 32'h0000_2000, 1,
                 32'h0000_0300, 32'h0000_9000, 1, 0);
        // R6 with 16-bit current stack wrapping
        run_case("same16 R6 R7", 0, 0, 2, 32'h5555_0001, 32'h0000_2000, 0,
                 32'h0000_0300, 32'h0000_9000, 1, 0);
        // R9: maximum count
        run_case("max R9", 1, 1, 31, 32'h0000_4000, 32'h0100_0000, 1,
                 32'h0000_2000, 32'h0200_0000, 1, 0);
        // R12: start pulsed while busy
        run_case("busy R12", 1, 1, 1, 32'h0000_0600, 32'h0300_0000, 1,
                 32'h0000_0A00, 32'h0400_0000, 1, 1);
        finished = 1;
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++; bad++;
            $display("FAIL watchdog act=%h exp=%h", 32'd0, 32'd1);
            $display("test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end
endmodule